// File: doc/BRIEF.md
# Sample Memory DMA Bridge

This block moves sample data between a byte-wide, 1 MB sample memory and one system DMA channel. A one-cycle `start` pulse loads a job configuration: a 20-bit starting unit address, a direction, a byte or word unit size, and a sign-invert option. The bridge then moves one unit for each DMA handshake until the channel signals that it has no data, flags the last unit, or the unit limit is reached. At that point the bridge drops `busy` and pulses `done`.

In word mode each unit is two bytes. The unit address is remapped to a byte address. The two bank bits are kept, and the low seventeen bits are doubled. The low byte goes to the even byte address and the high byte to the odd one. The optional inversion flips the sign bit of each sample. This converts between signed and unsigned samples in either direction.

The controller runs as a state machine. From `ST_IDLE`, a start pulse leads either into the memory-read path or into the channel-read path. The memory-read path is `ST_RD_LO` (issue the low read), `ST_RD_HI` (latch the low byte and issue the high read in word mode), `ST_RD_CAP` (latch the high byte, word mode only) and `ST_OFFER` (present the unit and wait for acknowledge). The channel-read path is `ST_FETCH` (request a unit and wait for acknowledge), `ST_WR_LO` and `ST_WR_HI` (write the low and high bytes). An acknowledge in `ST_OFFER` returns to `ST_RD_LO`, and the last write returns to `ST_FETCH`. Any end condition leads to `ST_FINISH` (one cycle, `done`), which returns to `ST_IDLE`.

Top module: `wdma_bridge`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `chan_req`, `mem_rd` and `mem_wr` are all 0.
- R2: `busy` is 1 from the clock edge that samples `start` until the end of the job. In the cycle `busy` falls, `done` is 1 for exactly one cycle.
- R3: With `cfg_to_chan`=1, each unit is read from the sample memory and offered on `chan_wdata` with `chan_req`=1. In byte mode the unit is the byte at the unit address, zero-extended to 16 bits.
- R4: With `cfg_to_chan`=0, each unit acknowledged on the channel is written into the sample memory. In byte mode only `chan_rdata[7:0]` is written.
- R5: After each completed unit, the unit address increments by one and wraps from 0xFFFFF to 0x00000.
- R6: With `cfg_wide`=1, the byte address of the low byte is {addr[19:18], addr[16:0], 0}, where addr is the unit address. Unit address bit 17 is discarded.
- R7: In word mode the low byte (data bits 7:0) is at the even byte address and the high byte (bits 15:8) at the following odd address.
- R8: With `cfg_flip`=1, data is XORed with 0x0080 in byte mode and 0x8080 in word mode, in both directions.
- R9: An acknowledge with `chan_empty`=1 ends the job at once. No memory write and no address increment follow for that unit.
- R10: An acknowledge with `chan_last`=1 completes that unit and then ends the job.
- R11: A job moves at most `MAX_UNITS` units, then ends without a further request.
- R12: A `start` pulse while `busy` is 1 is ignored. The running job keeps its configuration, and no new job follows.
- R13: `chan_req` stays high until `chan_ack`, and `mem_rd` and `mem_wr` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle job start, honoured only when idle |
| cfg_to_chan | input | 1 | 1: memory to channel, 0: channel to memory |
| cfg_wide | input | 1 | 1: two-byte units with address remap |
| cfg_flip | input | 1 | 1: invert the sample sign bit(s) |
| cfg_addr | input | 20 | Starting unit address |
| mem_addr | output | 20 | Sample memory byte address |
| mem_rd | output | 1 | Memory read strobe; data valid the next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte |
| chan_req | output | 1 | Unit request to the DMA channel |
| chan_dir | output | 1 | Direction of the running job |
| chan_wdata | output | 16 | Unit offered to the channel |
| chan_ack | input | 1 | Channel accepts or supplies a unit |
| chan_empty | input | 1 | With ack: channel has no data, stop |
| chan_last | input | 1 | With ack: this unit is terminal count |
| chan_rdata | input | 16 | Unit supplied by the channel |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle job completion pulse |

## Verification
A wrong address register shows on `mem_addr` at the next memory access. In word mode a wrong bank or doubling is visible within two cycles of entering a read or write state. A mis-latched data byte appears on `chan_wdata` by the next offer, or in memory at the next write. A wrong end decision shows as an extra or missing `chan_req` within one or two cycles of the deciding acknowledge. The directed scenarios cover the address wrap, the bank remap with bit 17 set, both inversion widths, the empty and last flags, the unit limit, and a start pulse during a job.

// File: rtl/wdb_pkg.sv
package wdb_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_RD_HI,
        ST_RD_CAP,
        ST_OFFER,
        ST_FETCH,
        ST_WR_LO,
        ST_WR_HI,
        ST_FINISH
    } wdb_state_e;

    localparam int unsigned UNIT_W = 16;
    localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/wdb_addr_map.sv
module wdb_addr_map #(
    parameter int unsigned ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] unit_addr,
    input  logic              wide,
    input  logic              hi_sel,
    output logic [ADDR_W-1:0] byte_addr
);
    // Word mode keeps the two bank bits and doubles the rest below bit ADDR_W-3.
    localparam int unsigned LOW_W = ADDR_W - 3;

    always_comb begin
        if (wide) begin
            byte_addr = {unit_addr[ADDR_W-1 -: 2], unit_addr[LOW_W-1:0], hi_sel};
        end else begin
            byte_addr = unit_addr;
        end
    end
endmodule

// File: rtl/wdb_sign_flip.sv
module wdb_sign_flip #(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] din,
    input  logic              enable,
    input  logic              wide,
    output logic [DATA_W-1:0] dout
);
    localparam int unsigned HALF = DATA_W / 2;

    logic [DATA_W-1:0] mask;

    always_comb begin
        mask = '0;
        mask[HALF-1] = enable;
        mask[DATA_W-1] = enable & wide;
        dout = din ^ mask;
    end
endmodule

// File: rtl/wdma_bridge.sv
module wdma_bridge
    import wdb_pkg::*;
#(
    parameter int unsigned ADDR_W    = 20,
    parameter int unsigned MAX_UNITS = 65536
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_to_chan,
    input  logic              cfg_wide,
    input  logic              cfg_flip,
    input  logic [ADDR_W-1:0] cfg_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              chan_req,
    output logic              chan_dir,
    output logic [15:0]       chan_wdata,
    input  logic              chan_ack,
    input  logic              chan_empty,
    input  logic              chan_last,
    input  logic [15:0]       chan_rdata,
    output logic              busy,
    output logic              done
);
    localparam int unsigned CNT_W = (MAX_UNITS > 1) ? $clog2(MAX_UNITS) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MAX_UNITS - 1);

    wdb_state_e state_q, state_d;

    logic              dir_q, wide_q, flip_q, last_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [UNIT_W-1:0] word_q;
    logic [UNIT_W-1:0] rx_flipped, tx_flipped;
    logic              hi_sel, at_limit, unit_done;

    wdb_addr_map #(.ADDR_W(ADDR_W)) u_map (
        .unit_addr (addr_q),
        .wide      (wide_q),
        .hi_sel    (hi_sel),
        .byte_addr (mem_addr)
    );

    wdb_sign_flip #(.DATA_W(UNIT_W)) u_flip_rx (
        .din    (chan_rdata),
        .enable (flip_q),
        .wide   (wide_q),
        .dout   (rx_flipped)
    );

    wdb_sign_flip #(.DATA_W(UNIT_W)) u_flip_tx (
        .din    (word_q),
        .enable (flip_q),
        .wide   (wide_q),
        .dout   (tx_flipped)
    );

    assign at_limit  = (cnt_q == CNT_TOP);
    assign unit_done = ((state_q == ST_OFFER) && chan_ack && !chan_empty)
                    || ((state_q == ST_WR_LO) && !wide_q)
                    ||  (state_q == ST_WR_HI);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = cfg_to_chan ? ST_RD_LO : ST_FETCH;
            ST_RD_LO:  state_d = ST_RD_HI;
            ST_RD_HI:  state_d = wide_q ? ST_RD_CAP : ST_OFFER;
            ST_RD_CAP: state_d = ST_OFFER;
            ST_OFFER: begin
                if (chan_ack) begin
                    if (chan_empty || chan_last || at_limit) state_d = ST_FINISH;
                    else                                      state_d = ST_RD_LO;
                end
            end
            ST_FETCH: begin
                if (chan_ack) state_d = chan_empty ? ST_FINISH : ST_WR_LO;
            end
            ST_WR_LO: begin
                if (wide_q)                  state_d = ST_WR_HI;
                else if (last_q || at_limit) state_d = ST_FINISH;
                else                         state_d = ST_FETCH;
            end
            ST_WR_HI:  state_d = (last_q || at_limit) ? ST_FINISH : ST_FETCH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            wide_q <= 1'b0;
            flip_q <= 1'b0;
            last_q <= 1'b0;
            addr_q <= '0;
            cnt_q  <= '0;
            word_q <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                dir_q  <= cfg_to_chan;
                wide_q <= cfg_wide;
                flip_q <= cfg_flip;
                addr_q <= cfg_addr;
                cnt_q  <= '0;
                last_q <= 1'b0;
            end
            if (state_q == ST_RD_HI) begin
                word_q <= {8'h00, mem_rdata};
            end
            if (state_q == ST_RD_CAP) begin
                word_q[15:8] <= mem_rdata;
            end
            if (state_q == ST_FETCH && chan_ack && !chan_empty) begin
                word_q <= rx_flipped;
                last_q <= chan_last;
            end
            if (unit_done) begin
                addr_q <= addr_q + 1'b1;
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        hi_sel     = (state_q == ST_RD_HI) || (state_q == ST_WR_HI);
        mem_rd     = (state_q == ST_RD_LO) || ((state_q == ST_RD_HI) && wide_q);
        mem_wr     = (state_q == ST_WR_LO) || (state_q == ST_WR_HI);
        mem_wdata  = (state_q == ST_WR_HI) ? word_q[15:8] : word_q[7:0];
        chan_req   = (state_q == ST_OFFER) || (state_q == ST_FETCH);
        chan_dir   = dir_q;
        chan_wdata = tx_flipped;
        busy       = (state_q != ST_IDLE) && (state_q != ST_FINISH);
        done       = (state_q == ST_FINISH);
    end
endmodule

// File: rtl/wdb_checker.sv
module wdb_checker #(
    parameter int unsigned ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              chan_req,
    input logic              chan_ack,
    input logic              chan_dir,
    input logic              wide_q,
    input logic              busy,
    input logic              done
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!chan_req && !mem_rd && !mem_wr));

    assert_done_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_read_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> chan_dir);

    assert_write_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !chan_dir);

    assert_hi_follows_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && wide_q && mem_addr[0]) |->
            ($past(mem_wr) && ($past(mem_addr) == {mem_addr[ADDR_W-1:1], 1'b0})));

    assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_req && !chan_ack) |=> chan_req);

    assert_mem_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
endmodule

bind wdma_bridge wdb_checker #(.ADDR_W(ADDR_W)) u_wdb_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .chan_req (chan_req),
    .chan_ack (chan_ack),
    .chan_dir (chan_dir),
    .wide_q   (wide_q),
    .busy     (busy),
    .done     (done)
);

// File: tb/wdma_bridge_tb_top.sv
module wdma_bridge_tb_top;
    localparam int MAXU = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cfg_to_chan = 1'b0;
    logic        cfg_wide = 1'b0;
    logic        cfg_flip = 1'b0;
    logic [19:0] cfg_addr = '0;
    logic [19:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        chan_req, chan_dir;
    logic [15:0] chan_wdata;
    logic        chan_ack = 1'b0;
    logic        chan_empty = 1'b0;
    logic        chan_last = 1'b0;
    logic [15:0] chan_rdata = '0;
    logic        busy, done;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wdma_bridge #(.ADDR_W(20), .MAX_UNITS(MAXU)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_to_chan(cfg_to_chan), .cfg_wide(cfg_wide), .cfg_flip(cfg_flip),
        .cfg_addr(cfg_addr),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .chan_req(chan_req), .chan_dir(chan_dir), .chan_wdata(chan_wdata),
        .chan_ack(chan_ack), .chan_empty(chan_empty), .chan_last(chan_last),
        .chan_rdata(chan_rdata), .busy(busy), .done(done)
    );

    // Sample memory model: one-cycle read latency
    logic [7:0] mem_model [int unsigned];

    function automatic logic [7:0] peek(int unsigned a);
        return mem_model.exists(a) ? mem_model[a] : 8'h00;
    endfunction

    always @(posedge clk) begin
        if (mem_wr) mem_model[int'(mem_addr)] = mem_wdata;
        if (mem_rd) mem_rdata <= peek(int'(mem_addr));
    end

    // DMA channel model, driven at the falling edge
    int          empty_at = -1;
    int          last_at = -1;
    int          acks = 0;
    logic        prev_busy = 1'b0;
    logic [15:0] offered [0:15];

    always @(negedge clk) begin
        if (busy && !prev_busy) acks = 0;
        prev_busy = busy;
        if (chan_req && !chan_ack) begin
            if (acks < 16) offered[acks] = chan_wdata;
            chan_empty = (acks == empty_at);
            chan_last  = (acks == last_at);
            chan_rdata = 16'hA5C3 + 16'(acks) * 16'h1111;
            chan_ack   = 1'b1;
            acks++;
        end else begin
            chan_ack   = 1'b0;
            chan_empty = 1'b0;
            chan_last  = 1'b0;
        end
    end

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // Start a job and wait for its end, checking busy/done (R2)
    task automatic run_job(logic dir, logic wide, logic flip, logic [19:0] addr);
        int n = 0;
        @(negedge clk);
        cfg_to_chan = dir; cfg_wide = wide; cfg_flip = flip; cfg_addr = addr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", busy, 1);
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check("R2 done seen", done, 1);
        check("R2 busy low with done", busy, 0);
        @(negedge clk);
        check("R2 done one cycle", done, 0);
    endtask

    task automatic t_reset;
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 chan_req", chan_req, 0);
        check("R1 mem strobes", {mem_rd, mem_wr}, 0);
    endtask

    task automatic t_byte_to_chan;
        mem_model[32'h100] = 8'h10; mem_model[32'h101] = 8'h20;
        mem_model[32'h102] = 8'h30; mem_model[32'h103] = 8'h40;
        empty_at = -1; last_at = 3;
        run_job(1'b1, 1'b0, 1'b0, 20'h00100);
        check("R10 units with last", acks, 4);
        check("R3 unit0", offered[0], 16'h0010);
        check("R3 unit1", offered[1], 16'h0020);
        check("R3 unit3", offered[3], 16'h0040);
    endtask

    task automatic t_wrap;
        mem_model[32'hFFFFE] = 8'h11; mem_model[32'hFFFFF] = 8'h22;
        mem_model[32'h00000] = 8'h33;
        empty_at = -1; last_at = 2;
        run_job(1'b1, 1'b0, 1'b0, 20'hFFFFE);
        check("R5 before wrap", offered[1], 16'h0022);
        check("R5 after wrap", offered[2], 16'h0033);
    endtask

    task automatic t_byte_from_chan_flip;
        mem_model[32'h203] = 8'h77;
        empty_at = -1; last_at = 2;
        run_job(1'b0, 1'b0, 1'b1, 20'h00200);
        check("R4 R8 byte0", peek(32'h200), 8'h43);
        check("R4 R8 byte1", peek(32'h201), 8'h54);
        check("R8 byte2", peek(32'h202), 8'h65);
        check("R10 no write past last", peek(32'h203), 8'h77);
    endtask

    task automatic t_word_to_chan_flip;
        for (int i = 0; i < 6; i++) mem_model[32'h40006 + i] = 8'(i + 1);
        empty_at = -1; last_at = 2;
        run_job(1'b1, 1'b1, 1'b1, 20'h40003);
        check("R6 R7 R8 word0", offered[0], 16'h8281);
        check("R7 R8 word1", offered[1], 16'h8483);
        check("R6 R8 word2", offered[2], 16'h8685);
    endtask

    task automatic t_word_from_chan;
        mem_model[32'h40006] = 8'h99;
        empty_at = -1; last_at = 1;
        run_job(1'b0, 1'b1, 1'b0, 20'h60001);
        check("R6 R7 lo0", peek(32'h40002), 8'hC3);
        check("R7 hi0", peek(32'h40003), 8'hA5);
        check("R7 lo1", peek(32'h40004), 8'hD4);
        check("R7 hi1", peek(32'h40005), 8'hB6);
        check("R6 bit17 dropped", peek(32'h60002), 8'h00);
        check("R10 stop after last", peek(32'h40006), 8'h99);
    endtask

    task automatic t_empty;
        mem_model[32'h301] = 8'h5A;
        empty_at = 1; last_at = -1;
        run_job(1'b0, 1'b0, 1'b0, 20'h00300);
        check("R9 unit before empty", peek(32'h300), 8'hC3);
        check("R9 no write on empty", peek(32'h301), 8'h5A);
        check("R9 no further request", acks, 2);
    endtask

    task automatic t_limit;
        empty_at = -1; last_at = -1;
        run_job(1'b1, 1'b0, 1'b0, 20'h00100);
        check("R11 unit limit", acks, MAXU);
    endtask

    task automatic t_start_while_busy;
        int n = 0;
        empty_at = -1; last_at = 1;
        @(negedge clk);
        cfg_to_chan = 1'b1; cfg_wide = 1'b0; cfg_flip = 1'b0; cfg_addr = 20'h00100;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        cfg_to_chan = 1'b0; cfg_wide = 1'b1; cfg_flip = 1'b1; cfg_addr = 20'h00000;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check("R12 job kept direction", acks, 2);
        check("R12 job kept config", offered[1], 16'h0020);
        repeat (6) @(negedge clk);
        check("R12 no second job", busy, 0);
        check("R12 memory untouched", peek(32'h100), 8'h10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_to_chan();
        t_wrap();
        t_byte_from_chan_flip();
        t_word_to_chan_flip();
        t_word_from_chan();
        t_empty();
        t_limit();
        t_start_while_busy();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
        $finish;
    end
endmodule